// File: doc/BRIEF.md
# Pattern-driven store cleaning controller

This block sits next to an L1 data cache controller and decides, for every committed store, whether the cache line that store writes should also be cleaned. A clean sends the dirty line to lower memory and leaves the cached copy clean. Software loads a small set of slots. Each slot holds one store instruction address and a cleaning pattern of PAT_LEN bits.

When an accepted store carries the instruction address held in a slot, that slot's current pattern bit decides the outcome. A 1 makes the store raise a clean request for its line. A 0 lets the store complete as a plain write. The slot's pointer then steps to the next bit. Stores whose address is held in no slot pass through unchanged.

Clean requests leave through a valid/ready handshake. While a request is outstanding, the store input stalls.

Top module: `store_clean_ctrl`

## Requirements
- R1: After reset no clean request is pending, `st_ready` is high, every slot is empty, and a store at any instruction address raises no clean.
- R2: An accepted store whose instruction address matches a slot whose current pattern bit is 1 raises `cln_valid` in the cycle after acceptance. `cln_line` then equals the store's data address with its low log2(LINE_BYTES) bits dropped.
- R3: An accepted matching store whose current pattern bit is 0 raises no clean request.
- R4: Pattern bits are used starting at bit 0. The slot's pointer advances by one on each accepted matching store and wraps from PAT_LEN-1 back to 0, so the ninth matching store with PAT_LEN=8 uses bit 0 again.
- R5: A store that matches no slot raises no clean request and leaves every slot's pointer unchanged.
- R6: `cln_valid` and `cln_line` stay unchanged until a cycle with `cln_ready` high. `cln_valid` is low in the cycle after that handshake.
- R7: `st_ready` is low while a clean request is pending. A store held at `st_valid` during that time is not accepted and does not advance any pointer.
- R8: A configuration write (`cfg_we`, slot `cfg_idx`) loads the slot's instruction address and pattern, marks the slot valid and resets its pointer to 0.
- R9: When several slots match one store, the lowest-numbered slot decides the outcome. Only that slot's pointer advances.
- R10: When a configuration write and an accepted matching store hit the same slot in one cycle, the store is decided by the slot's old pattern and pointer. The slot then holds the new contents with pointer 0.
- R11: Each slot keeps its own pointer. Stores to one slot never move another slot's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load a slot this cycle |
| cfg_idx | input | IDX_W | Slot to load |
| cfg_pc | input | PC_W | Store instruction address for the slot |
| cfg_pattern | input | PAT_LEN | Cleaning pattern, bit 0 used first |
| st_valid | input | 1 | Committed store present |
| st_ready | output | 1 | Store accepted when high together with st_valid |
| st_pc | input | PC_W | Instruction address of the store |
| st_addr | input | ADDR_W | Data address of the store |
| cln_valid | output | 1 | Clean request pending |
| cln_ready | input | 1 | Cache controller takes the clean request |
| cln_line | output | ADDR_W-log2(LINE_BYTES) | Line address to clean |

## Verification
Two events can fall in the same cycle and need explicit checks.

The first is a configuration write colliding with a matching store on the same slot. The bench drives both on one edge. The old pattern has a 0 at the current pointer and the new pattern has a 1 at that index, so the bench can tell which contents decided the store. The next two stores must then follow the new pattern from bit 0.

The second is the end of a clean handshake while a store is waiting. The bench holds a matching store at `st_valid` through a stalled request. It checks that the store is accepted only after `cln_ready` retires the request, and that the store then uses the next pattern bit and not a later one.

// File: rtl/stclean_pkg.sv
package stclean_pkg;

   // Width of an index able to name n items; never zero.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/stclean_slot.sv
module stclean_slot #(
   parameter int PC_W    = 32,
   parameter int PAT_LEN = 8,
   parameter int PTR_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [PC_W-1:0]    load_pc,
   input  logic [PAT_LEN-1:0] load_pat,
   input  logic [PC_W-1:0]    probe_pc,
   input  logic               step,
   output logic               hit,
   output logic               cur_bit
);

   logic               vld_q;
   logic [PC_W-1:0]    pc_q;
   logic [PAT_LEN-1:0] pat_q;
   logic [PTR_W-1:0]   ptr_q;
   logic [PTR_W-1:0]   ptr_nxt;

   // Pointer wrap: free-running when the length fills the pointer range.
   generate
      if (stclean_pkg::is_pow2(PAT_LEN)) begin : g_wrap_natural
         assign ptr_nxt = ptr_q + PTR_W'(1);
      end else begin : g_wrap_compare
         assign ptr_nxt = (ptr_q == PTR_W'(PAT_LEN - 1)) ? '0 : ptr_q + PTR_W'(1);
      end
   endgenerate

   assign hit     = vld_q && (pc_q == probe_pc);
   assign cur_bit = pat_q[ptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         pc_q  <= '0;
         pat_q <= '0;
         ptr_q <= '0;
      end else if (load) begin
         vld_q <= 1'b1;
         pc_q  <= load_pc;
         pat_q <= load_pat;
         ptr_q <= '0;
      end else if (step) begin
         ptr_q <= ptr_nxt;
      end
   end

endmodule

// File: rtl/stclean_prio.sv
module stclean_prio #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);

   assign any = |req;

   generate
      if (N == 1) begin : g_single
         assign grant = req;
      end else begin : g_multi
         always_comb begin
            logic taken;
            taken = 1'b0;
            grant = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i] && !taken) begin
                  grant[i] = 1'b1;
                  taken    = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/stclean_issue.sv
module stclean_issue #(
   parameter int LINE_W = 27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [LINE_W-1:0] line_in,
   input  logic              req_ready,
   output logic              req_valid,
   output logic [LINE_W-1:0] req_line
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_line  <= '0;
      end else if (fire) begin
         req_valid <= 1'b1;
         req_line  <= line_in;
      end else if (req_valid && req_ready) begin
         req_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/store_clean_ctrl.sv
module store_clean_ctrl #(
   parameter int NUM_SLOTS  = 4,
   parameter int PC_W       = 32,
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int PAT_LEN    = 8,
   localparam int IDX_W     = stclean_pkg::idx_width(NUM_SLOTS),
   localparam int PTR_W     = stclean_pkg::idx_width(PAT_LEN),
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = ADDR_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [PC_W-1:0]    cfg_pc,
   input  logic [PAT_LEN-1:0] cfg_pattern,
   input  logic               st_valid,
   output logic               st_ready,
   input  logic [PC_W-1:0]    st_pc,
   input  logic [ADDR_W-1:0]  st_addr,
   output logic               cln_valid,
   input  logic               cln_ready,
   output logic [LINE_W-1:0]  cln_line
);

   // Elaboration-time parameter checks
   generate
      if (NUM_SLOTS < 1) begin : g_bad_slots
         $error("NUM_SLOTS must be at least 1");
      end
      if (PAT_LEN < 2) begin : g_bad_pat
         $error("PAT_LEN must be at least 2");
      end
      if (!stclean_pkg::is_pow2(LINE_BYTES)) begin : g_bad_line
         $error("LINE_BYTES must be a power of two");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("ADDR_W must exceed the line offset width");
      end
   endgenerate

   logic                 accept;
   logic [NUM_SLOTS-1:0] hit_v;
   logic [NUM_SLOTS-1:0] bit_v;
   logic [NUM_SLOTS-1:0] grant_v;
   logic                 any_hit;
   logic                 fire;

   assign st_ready = !cln_valid;
   assign accept   = st_valid && st_ready;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      stclean_slot #(
         .PC_W   (PC_W),
         .PAT_LEN(PAT_LEN),
         .PTR_W  (PTR_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (cfg_we && (cfg_idx == IDX_W'(s))),
         .load_pc (cfg_pc),
         .load_pat(cfg_pattern),
         .probe_pc(st_pc),
         .step    (accept && grant_v[s]),
         .hit     (hit_v[s]),
         .cur_bit (bit_v[s])
      );
   end

   stclean_prio #(.N(NUM_SLOTS)) u_prio (
      .req  (hit_v),
      .grant(grant_v),
      .any  (any_hit)
   );

   assign fire = accept && any_hit && |(grant_v & bit_v);

   stclean_issue #(.LINE_W(LINE_W)) u_issue (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .line_in  (st_addr[ADDR_W-1:OFF_W]),
      .req_ready(cln_ready),
      .req_valid(cln_valid),
      .req_line (cln_line)
   );

endmodule

// File: rtl/stclean_checker.sv
module stclean_checker #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    st_valid,
   input logic                    st_ready,
   input logic [ADDR_W-1:0]       st_addr,
   input logic                    cln_valid,
   input logic                    cln_ready,
   input logic [ADDR_W-OFF_W-1:0] cln_line
);

   // R7: the store path stalls while a clean is pending
   a_r7_stall_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
      cln_valid |-> !st_ready);

   // R6: an unanswered request holds its value
   a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (cln_valid && !cln_ready) |=> (cln_valid && $stable(cln_line)));

   // R6: a completed handshake retires the request
   a_r6_retire: assert property (@(posedge clk) disable iff (!rst_n)
      (cln_valid && cln_ready) |=> !cln_valid);

   // R2: a request only appears after an accepted store
   a_r2_from_store: assert property (@(posedge clk) disable iff (!rst_n)
      (!cln_valid && !(st_valid && st_ready)) |=> !cln_valid);

   // R2: the line is the accepted store's address without offset
   a_r2_line_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (!cln_valid && st_valid && st_ready) |=>
         (!cln_valid || cln_line == $past(st_addr[ADDR_W-1:OFF_W])));

endmodule

bind store_clean_ctrl stclean_checker #(
   .ADDR_W(ADDR_W),
   .OFF_W (OFF_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .st_valid (st_valid),
   .st_ready (st_ready),
   .st_addr  (st_addr),
   .cln_valid(cln_valid),
   .cln_ready(cln_ready),
   .cln_line (cln_line)
);

// File: tb/store_clean_ctrl_test.sv
module store_clean_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int NS   = 4;
   localparam int OFF  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [31:0] cfg_pc = '0;
   logic [7:0]  cfg_pattern = '0;
   logic        st_valid = 1'b0;
   logic        st_ready;
   logic [31:0] st_pc = '0;
   logic [31:0] st_addr = '0;
   logic        cln_valid;
   logic        cln_ready = 1'b0;
   logic [26:0] cln_line;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   store_clean_ctrl #(
      .NUM_SLOTS(NS), .PC_W(32), .ADDR_W(32), .LINE_BYTES(32), .PAT_LEN(8)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_pc(cfg_pc), .cfg_pattern(cfg_pattern),
      .st_valid(st_valid), .st_ready(st_ready), .st_pc(st_pc), .st_addr(st_addr),
      .cln_valid(cln_valid), .cln_ready(cln_ready), .cln_line(cln_line)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cfg(input int idx, input logic [31:0] pc, input logic [7:0] pat);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_pc = pc; cfg_pattern = pat;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk);
      cln_ready = 1'b1;
      @(posedge clk); #1;
      cln_ready = 1'b0;
      chk("R6 retire", {63'd0, cln_valid}, 64'd0);
   endtask

   task automatic do_store(input logic [31:0] pc, input logic [31:0] addr,
                           input bit exp, input string req);
      @(negedge clk);
      st_pc = pc; st_addr = addr; st_valid = 1'b1;
      @(posedge clk); #1;
      st_valid = 1'b0;
      chk(req, {63'd0, cln_valid}, {63'd0, exp});
      if (exp) chk({req, " line"}, {37'd0, cln_line}, {37'd0, 27'(addr >> OFF)});
      if (cln_valid) drain();
   endtask

   task automatic t_reset();
      chk("R1 no clean", {63'd0, cln_valid}, 64'd0);
      chk("R1 ready", {63'd0, st_ready}, 64'd1);
      do_store(32'h0, 32'h40, 1'b0, "R1 empty slots");
   endtask

   task automatic t_pattern();
      logic [7:0] pat = 8'b1010_0110;
      cfg(0, 32'h100, pat);
      for (int k = 0; k < 9; k++)
         do_store(32'h100, 32'h1000 + 32'(k) * 32, pat[k % 8],
                  (k == 8) ? "R4 wrap" : ((pat[k % 8]) ? "R2 clean bit" : "R3 plain bit"));
   endtask

   task automatic t_nomatch();
      cfg(1, 32'h200, 8'b0000_0011);
      do_store(32'h200, 32'h2000, 1'b1, "R11 slot1 bit0");
      for (int k = 0; k < 3; k++)
         do_store(32'h300, 32'h3000 + 32'(k) * 32, 1'b0, "R5 unmatched");
      do_store(32'h200, 32'h2020, 1'b1, "R5 pointer kept bit1");
      do_store(32'h200, 32'h2040, 1'b0, "R5 bit2");
      do_store(32'h100, 32'h1400, 1'b1, "R11 slot0 own pointer bit1");
   endtask

   task automatic t_stall();
      logic [26:0] held;
      cfg(2, 32'h400, 8'b0000_0101);
      @(negedge clk);
      st_pc = 32'h400; st_addr = 32'h4000; st_valid = 1'b1;
      @(posedge clk); #1;
      chk("R2 stall first clean", {63'd0, cln_valid}, 64'd1);
      held = cln_line;
      @(negedge clk);
      st_addr = 32'h4020;          // held store, stays valid
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); #1;
         chk("R7 ready low", {63'd0, st_ready}, 64'd0);
         chk("R6 hold", {37'd0, cln_line}, {37'd0, held});
      end
      @(negedge clk);
      cln_ready = 1'b1;
      @(posedge clk); #1;
      cln_ready = 1'b0;
      chk("R6 released", {63'd0, cln_valid}, 64'd0);
      @(posedge clk); #1;           // held store accepted here, bit1 = 0
      st_valid = 1'b0;
      chk("R7 held store uses bit1", {63'd0, cln_valid}, 64'd0);
      do_store(32'h400, 32'h4040, 1'b1, "R7 next store bit2");
   endtask

   task automatic t_prio();
      cfg(3, 32'h500, 8'hFF);
      cfg(1, 32'h500, 8'h00);
      do_store(32'h500, 32'h5000, 1'b0, "R9 lower slot wins");
      do_store(32'h500, 32'h5020, 1'b0, "R9 lower slot wins again");
      cfg(1, 32'h600, 8'h01);
      do_store(32'h500, 32'h5040, 1'b1, "R9 slot3 unmoved");
      do_store(32'h600, 32'h6000, 1'b1, "R8 reload bit0");
      do_store(32'h600, 32'h6020, 1'b0, "R8 reload bit1");
   endtask

   task automatic t_same_cycle();
      // slot2 pointer is 3 here; old bit3 = 0, new pattern bit3 = 1
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 2'd2; cfg_pc = 32'h400; cfg_pattern = 8'b0000_1010;
      st_pc = 32'h400; st_addr = 32'h4400; st_valid = 1'b1;
      @(posedge clk); #1;
      cfg_we = 1'b0; st_valid = 1'b0;
      chk("R10 old contents decide", {63'd0, cln_valid}, 64'd0);
      if (cln_valid) drain();
      do_store(32'h400, 32'h4420, 1'b0, "R10 new bit0");
      do_store(32'h400, 32'h4440, 1'b1, "R10 new bit1");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pattern();
      t_nomatch();
      t_stall();
      t_prio();
      t_same_cycle();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule